// File: doc/BRIEF.md
# Iterative Right Shifter with Down-Counter

This block performs a logical right shift one bit position per clock, with a down-counter setting how many positions. An external sequencer first loads the count from a 5-bit constant field of the current instruction. If that field is zero, a second load strobe fetches the count from the low five bits of a register value on the bus. The operand is then copied unchanged from the bus into the 32-bit result register C.

While the sequencer holds the step strobe, each clock shifts C right by one with a zero entering the top bit, and decrements the counter. The block reports a counter-is-zero flag, which the sequencer uses as its loop exit test. It also gives a one-cycle done pulse after the step that empties the counter. When both count sources give zero, C keeps the unshifted operand.

Top module: `shr_unit`

## Requirements
- R1: After reset, cOut is 0, the counter is 0, cntZero is 1 and shiftDone is 0.
- R2: A cycle with ldConst high loads the counter from irConst[4:0]. ldConst takes priority over ldReg in the same cycle.
- R3: A cycle with ldReg high and ldConst low loads the counter from busIn[4:0] only when the counter is zero. When the counter is nonzero, ldReg is ignored and the counter keeps its value.
- R4: A cycle with loadC high copies busIn unchanged into C.
- R5: A step cycle is one with shiftStep high, the counter nonzero and no load strobe (ldConst, ldReg, loadC) high. In a step cycle, C becomes {0, C[31:1]} and the counter drops by one. Holding shiftStep therefore shifts C by exactly the loaded count.
- R6: shiftStep while the counter is zero leaves C and the counter unchanged.
- R7: cntZero is high exactly when the counter holds zero.
- R8: shiftDone is high for exactly one cycle, the cycle after a step that took the counter from 1 to 0. It is low at all other times.
- R9: A load strobe in the same cycle as shiftStep blocks the step. The load takes effect and no shift or decrement happens.
- R10: When irConst and busIn[4:0] are both zero, C keeps the loaded operand unshifted and no done pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busIn | input | 32 | Shared bus value: operand or register count source |
| irConst | input | 5 | Shift-amount constant field of the instruction |
| ldConst | input | 1 | Load counter from irConst |
| ldReg | input | 1 | Load counter from busIn[4:0] when counter is zero |
| loadC | input | 1 | Copy busIn into C |
| shiftStep | input | 1 | Request one shift-and-decrement step |
| cOut | output | 32 | Contents of C |
| cntZero | output | 1 | Counter equals zero |
| shiftDone | output | 1 | One-cycle pulse after the final step |

## Verification
The assertions check the following on every cycle:
- each step moves C right by one with zero fill and lowers the count by one;
- a step request with an empty counter changes nothing;
- a constant load lands in the counter, and ldReg leaves a nonzero count alone;
- loadC copies the bus;
- done appears only with an empty counter, right after a step from one.

Only the bench scenarios show the end-to-end properties: that the number of steps equals the chosen count source, that the final value is the operand shifted by that amount, that the two load strobes follow their priority, and that zero from both sources leaves the operand unchanged.

// File: rtl/shr_pkg.sv
package shr_pkg;
  typedef struct packed {
    logic cntLoadIr;
    logic cntLoadBus;
    logic cntDecr;
    logic cLoad;
    logic cShift;
  } shr_strobe_t;
endpackage

// File: rtl/shr_counter.sv
module shr_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadIr,
  input  logic             loadBus,
  input  logic             decr,
  input  logic [CNT_W-1:0] irVal,
  input  logic [CNT_W-1:0] busVal,
  output logic [CNT_W-1:0] cnt,
  output logic             isZero,
  output logic             isOne
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cntQ <= '0;
    else if (loadIr)  cntQ <= irVal;
    else if (loadBus) cntQ <= busVal;
    else if (decr)    cntQ <= cntQ - ONE;
  end

  assign cnt    = cntQ;
  assign isZero = (cntQ == '0);
  assign isOne  = (cntQ == ONE);
endmodule

// File: rtl/shr_creg.sv
module shr_creg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] cQ;
  logic [DATA_W-1:0] cNext;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic fill;
    if (i == DATA_W - 1) begin : g_top
      assign fill = 1'b0;
    end else begin : g_mid
      assign fill = cQ[i+1];
    end
    assign cNext[i] = load ? din[i] : (shift ? fill : cQ[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cQ <= '0;
    else       cQ <= cNext;
  end

  assign q = cQ;
endmodule

// File: rtl/shr_datapath.sv
module shr_datapath
  import shr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  shr_strobe_t       stb,
  input  logic [DATA_W-1:0] busIn,
  input  logic [CNT_W-1:0]  irConst,
  output logic [DATA_W-1:0] cOut,
  output logic [CNT_W-1:0]  cntVal,
  output logic              cntZero,
  output logic              cntOne
);
  shr_counter #(.CNT_W(CNT_W)) counter_i (
    .clk     (clk),
    .rstN    (rstN),
    .loadIr  (stb.cntLoadIr),
    .loadBus (stb.cntLoadBus),
    .decr    (stb.cntDecr),
    .irVal   (irConst),
    .busVal  (busIn[CNT_W-1:0]),
    .cnt     (cntVal),
    .isZero  (cntZero),
    .isOne   (cntOne)
  );

  shr_creg #(.DATA_W(DATA_W)) creg_i (
    .clk   (clk),
    .rstN  (rstN),
    .load  (stb.cLoad),
    .shift (stb.cShift),
    .din   (busIn),
    .q     (cOut)
  );
endmodule

// File: rtl/shr_ctrl.sv
module shr_ctrl
  import shr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ldConst,
  input  logic        ldReg,
  input  logic        loadC,
  input  logic        shiftStep,
  input  logic        cntZero,
  input  logic        cntOne,
  output shr_strobe_t stb,
  output logic        shiftDone
);
  logic anyLoad;
  logic stepGo;
  logic doneQ;

  assign anyLoad = ldConst | ldReg | loadC;
  assign stepGo  = shiftStep & ~cntZero & ~anyLoad;

  always_comb begin
    stb            = '0;
    stb.cntLoadIr  = ldConst;
    stb.cntLoadBus = ldReg & ~ldConst & cntZero;
    stb.cntDecr    = stepGo;
    stb.cLoad      = loadC;
    stb.cShift     = stepGo;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= stepGo & cntOne;
  end

  assign shiftDone = doneQ;
endmodule

// File: rtl/shr_unit.sv
module shr_unit
  import shr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] busIn,
  input  logic [4:0]        irConst,
  input  logic              ldConst,
  input  logic              ldReg,
  input  logic              loadC,
  input  logic              shiftStep,
  output logic [DATA_W-1:0] cOut,
  output logic              cntZero,
  output logic              shiftDone
);
  localparam int CNT_W = $clog2(DATA_W);

  shr_strobe_t      stb;
  logic [CNT_W-1:0] cntVal;
  logic             cntOne;

  shr_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .ldConst   (ldConst),
    .ldReg     (ldReg),
    .loadC     (loadC),
    .shiftStep (shiftStep),
    .cntZero   (cntZero),
    .cntOne    (cntOne),
    .stb       (stb),
    .shiftDone (shiftDone)
  );

  shr_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .busIn   (busIn),
    .irConst (irConst[CNT_W-1:0]),
    .cOut    (cOut),
    .cntVal  (cntVal),
    .cntZero (cntZero),
    .cntOne  (cntOne)
  );
endmodule

// File: rtl/shr_unit_chk.sv
module shr_unit_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] busIn,
  input logic [CNT_W-1:0]  irConst,
  input logic              ldConst,
  input logic              ldReg,
  input logic              loadC,
  input logic              shiftStep,
  input logic [DATA_W-1:0] cOut,
  input logic              cntZero,
  input logic              shiftDone,
  input logic [CNT_W-1:0]  cntVal
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic noLoad;
  assign noLoad = !ldConst && !ldReg && !loadC;

  AST_STEP_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    (shiftStep && !cntZero && noLoad) |=> (cOut == ($past(cOut) >> 1)) && (cntVal == $past(cntVal) - ONE)); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (shiftStep && cntZero && noLoad) |=> $stable(cOut) && cntZero); // R6

  AST_CONST_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    ldConst |=> cntVal == $past(irConst)); // R2

  AST_REG_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (ldReg && !ldConst && !cntZero) |=> $stable(cntVal)); // R3

  AST_LOADC_COPY: assert property (@(posedge clk) disable iff (!rstN)
    loadC |=> cOut == $past(busIn)); // R4

  AST_DONE_ORIGIN: assert property (@(posedge clk) disable iff (!rstN)
    shiftDone |-> cntZero && ($past(cntVal) == ONE) && $past(shiftStep)); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    shiftDone |=> !shiftDone); // R8
endmodule

bind shr_unit shr_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .busIn     (busIn),
  .irConst   (irConst[CNT_W-1:0]),
  .ldConst   (ldConst),
  .ldReg     (ldReg),
  .loadC     (loadC),
  .shiftStep (shiftStep),
  .cOut      (cOut),
  .cntZero   (cntZero),
  .shiftDone (shiftDone),
  .cntVal    (cntVal)
);

// File: tb/shr_unit_tb_top.sv
module shr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] busIn = '0;
  logic [4:0]  irConst = '0;
  logic        ldConst = 1'b0;
  logic        ldReg = 1'b0;
  logic        loadC = 1'b0;
  logic        shiftStep = 1'b0;
  logic [31:0] cOut;
  logic        cntZero;
  logic        shiftDone;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  shr_unit dut_i (
    .clk(clk), .rstN(rstN), .busIn(busIn), .irConst(irConst),
    .ldConst(ldConst), .ldReg(ldReg), .loadC(loadC), .shiftStep(shiftStep),
    .cOut(cOut), .cntZero(cntZero), .shiftDone(shiftDone)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Hold shiftStep until the counter empties; checks count, result and done.
  task automatic runLoop(input string req, input logic [31:0] operand, input int n);
    int steps = 0;
    int doneCnt = 0;
    logic [31:0] held;
    while (!cntZero && steps < 40) begin
      shiftStep = 1'b1;
      tick();
      steps++;
      if (shiftDone) doneCnt++;
    end
    shiftStep = 1'b0;
    check(steps == n, {req, " R5 step count"}, 32'(steps), 32'(n));
    check(cOut == (operand >> n), {req, " R5 result"}, cOut, operand >> n);
    check(doneCnt == ((n > 0) ? 1 : 0), {req, " R8 done pulses"}, 32'(doneCnt), (n > 0) ? 32'd1 : 32'd0);
    check(shiftDone == (n > 0), {req, " R8 done at end"}, 32'(shiftDone), 32'(n > 0));
    held = cOut;
    shiftStep = 1'b1;
    tick();
    shiftStep = 1'b0;
    check(cOut == held && cntZero, {req, " R6 idle step"}, cOut, held);
    check(!shiftDone, {req, " R8 no repeat done"}, 32'(shiftDone), 32'd0);
  endtask

  task automatic runShift(input string req, input logic [4:0] irc, input logic [31:0] busCnt,
                          input logic [31:0] operand, input int n);
    ldConst = 1'b1; irConst = irc;
    tick();
    ldConst = 1'b0; ldReg = 1'b1; busIn = busCnt;
    tick();
    ldReg = 1'b0; loadC = 1'b1; busIn = operand;
    tick();
    loadC = 1'b0; busIn = 32'hFFFF_FFFF;
    check(cOut == operand, {req, " R4 operand copy"}, cOut, operand);
    check(cntZero == (n == 0), {req, " R7 zero flag"}, 32'(cntZero), 32'(n == 0));
    runLoop(req, operand, n);
  endtask

  task automatic testReset();
    check(cOut == '0, "R1 C reset", cOut, '0);
    check(cntZero, "R1 R7 counter reset", 32'(cntZero), 32'd1);
    check(!shiftDone, "R1 done reset", 32'(shiftDone), 32'd0);
  endtask

  task automatic testPriority();
    ldConst = 1'b1; irConst = 5'd2; ldReg = 1'b1; busIn = 32'd6;
    tick();
    ldConst = 1'b0; ldReg = 1'b0; loadC = 1'b1; busIn = 32'hF0F0_1234;
    tick();
    loadC = 1'b0;
    runLoop("R2 priority", 32'hF0F0_1234, 2);
  endtask

  task automatic testBlockedStep();
    ldConst = 1'b1; irConst = 5'd4;
    tick();
    ldConst = 1'b0; loadC = 1'b1; busIn = 32'h1111_1111;
    tick();
    shiftStep = 1'b1; busIn = 32'h8765_4321;
    tick();
    shiftStep = 1'b0; loadC = 1'b0;
    check(cOut == 32'h8765_4321, "R9 load wins over step", cOut, 32'h8765_4321);
    runLoop("R9 count kept", 32'h8765_4321, 4);
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tick(); tick();
    testReset();
    rstN = 1'b1;
    tick();
    runShift("R2 const count", 5'd5, 32'd0, 32'hDEAD_BEEF, 5);
    runShift("R3 reg count", 5'd0, 32'hFFFF_FFE7, 32'h8000_0001, 7);
    runShift("R3 reg ignored", 5'd3, 32'd9, 32'hCAFE_F00D, 3);
    runShift("R5 full count", 5'd31, 32'd0, 32'hFFFF_FFFF, 31);
    runShift("R5 single", 5'd1, 32'd0, 32'h8000_0000, 1);
    runShift("R10 both zero", 5'd0, 32'hFFFF_FFE0, 32'h1234_5678, 0);
    testPriority();
    testBlockedStep();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule